// File: doc/BRIEF.md
# Half-Bridge Sweep Oscillator with Dead Time

This block is a digital oscillator that drives the two gate enables of a half-bridge power stage. Its master clock has 50 % duty. The high-side gate conducts in the high half of each master cycle and the low-side gate in the low half. Each gate turns on only after a programmable dead-time count has elapsed inside its half, so the two gates never overlap. All periods are given as half-period counts of the system clock.

A sequencer drives a two-bit select code. In sweep mode the half period starts from a preheat value and climbs once per master cycle toward an end-of-sweep value. Each step covers a programmable binary fraction of the remaining distance, so the output frequency falls fastest at first and settles on the end value. In operate mode the next master cycle jumps straight to the operating half period, with no ramp. Two static modes cover the rest of the sequence. In forced-off mode both gates are low. In low-side-only mode the low-side gate is held on for power-up.

A new half period takes effect only at the start of a master cycle. This means no runt half cycle is ever produced.

Top module: `hb_sweep_osc`

## Requirements
- R1: After `rst_ni` is released, `mclk_o`, `hi_o` and `lo_o` are low. The first clock edge after release is a master-cycle boundary, and at that edge `mclk_o` goes high.
- R2: `mclk_o` stays high for H clock cycles and then low for H cycles. H is the half period latched at the boundary that started the cycle. A requested half period of 0 is treated as 1.
- R3: The half period is sampled only at a boundary. A boundary is the clock edge that ends a low half, so a change of select code or period input never shortens or stretches a half already running.
- R4: With `sel_i` = 2 (sweep), a pulse on `sweep_start_i` loads the sweep value with `pre_half_i`. At each boundary in sweep mode, a sweep value S below `end_half_i` becomes S + max(1, (`end_half_i` − S) >> `sweep_k_i`). A boundary uses the sweep value as it stood before that edge's step.
- R5: A sweep value at or above `end_half_i` becomes exactly `end_half_i` at the next sweep step. The sweep therefore settles on the end value and never passes it.
- R6: With `sel_i` = 3 (operate), the next boundary latches `op_half_i` directly.
- R7: In sweep and operate modes, `hi_o` is high in the high half, and `lo_o` in the low half, only once at least `dead_i` cycles of that half have elapsed. Both drop at once when their half ends. If `dead_i` ≥ H, the gate stays low for the whole half.
- R8: `hi_o` and `lo_o` are never high together.
- R9: With `sel_i` = 0 (forced off), both gates are low whatever the oscillator state.
- R10: With `sel_i` = 1 (low-side only), `lo_o` is high and `hi_o` is low. The oscillator keeps running on the sweep value in modes 0 and 1, and the sweep value does not step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 2 | Mode select: 0 off, 1 low-side only, 2 sweep, 3 operate |
| sweep_start_i | input | 1 | Loads the preheat half period into the sweep value |
| pre_half_i | input | HW | Preheat half period (clock cycles) |
| end_half_i | input | HW | End-of-sweep half period |
| op_half_i | input | HW | Operating half period |
| sweep_k_i | input | KW | Sweep time-constant shift |
| dead_i | input | DW | Dead time in clock cycles |
| mclk_o | output | 1 | 50 % master clock |
| hi_o | output | 1 | High-side gate enable |
| lo_o | output | 1 | Low-side gate enable |

## Verification
The bench targets the last small steps of the sweep, where a shifted difference of zero would leave the period stuck one or more counts short of the end value. It also loads a preheat value above the end value, where a design without the clamp would run past it. It changes the select code in the middle of a half, which exposes a design that applies the new period early as a runt or stretched half. It sets the dead time equal to the half period, where an off-by-one comparison would give a one-cycle gate pulse. It also uses a half period of zero, which would hang a counter that lacks the clamp.

// File: rtl/hb_osc_pkg.sv
package hb_osc_pkg;
  typedef enum logic [1:0] {
    SEL_OFF     = 2'd0,
    SEL_LOWONLY = 2'd1,
    SEL_SWEEP   = 2'd2,
    SEL_OPER    = 2'd3
  } sel_e;
endpackage

// File: rtl/hb_sweep_step.sv
module hb_sweep_step #(
  parameter int HW = 16,
  parameter int KW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          adv_i,
  input  logic [HW-1:0] pre_h_i,
  input  logic [HW-1:0] end_h_i,
  input  logic [KW-1:0] k_i,
  output logic [HW-1:0] h_o
);
  logic [HW-1:0] h_q, diff, inc, nxt;

  always_comb begin
    diff = end_h_i - h_q;
    inc  = diff >> k_i;
    if (inc == '0) inc = {{(HW-1){1'b0}}, 1'b1};
    // saturating step: lands on end value exactly
    nxt = (h_q >= end_h_i) ? end_h_i : h_q + inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      h_q <= '0;
    else if (start_i) h_q <= pre_h_i;
    else if (adv_i)   h_q <= nxt;
  end

  assign h_o = h_q;

  // R4
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> h_q == $past(pre_h_i));
  // R4
  rises_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !start_i && h_q < end_h_i) |=> h_q > $past(h_q));
  // R5
  clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !start_i && h_q >= end_h_i) |=> h_q == $past(end_h_i));
endmodule

// File: rtl/hb_phase_gen.sv
module hb_phase_gen #(
  parameter int HW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [HW-1:0] next_h_i,
  output logic          mclk_o,
  output logic [HW-1:0] el_o,
  output logic          bnd_o
);
  localparam logic [HW-1:0] ONE = {{(HW-1){1'b0}}, 1'b1};

  logic          ph_q;
  logic [HW-1:0] el_q, half_q, new_h;
  logic          half_end;

  assign half_end = (el_q == half_q - ONE);
  assign bnd_o    = !ph_q && half_end;
  assign new_h    = (next_h_i == '0) ? ONE : next_h_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= 1'b0;
      el_q   <= '0;
      half_q <= ONE;
    end else if (half_end) begin
      el_q <= '0;
      ph_q <= !ph_q;
      if (!ph_q) half_q <= new_h;
    end else begin
      el_q <= el_q + ONE;
    end
  end

  assign mclk_o = ph_q;
  assign el_o   = el_q;

  // R2
  el_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    el_q < half_q);
  // R3
  bnd_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_o |=> mclk_o && el_q == '0);
  // R3
  half_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd_o |=> half_q == $past(half_q));
endmodule

// File: rtl/hb_gate_drive.sv
module hb_gate_drive
  import hb_osc_pkg::*;
#(
  parameter int HW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  sel_e          sel_i,
  input  logic          ph_i,
  input  logic [HW-1:0] el_i,
  input  logic [DW-1:0] dt_i,
  output logic          hi_o,
  output logic          lo_o
);
  localparam int CW = (HW > DW) ? HW : DW;

  logic [CW-1:0] el_w, dt_w;
  logic          en;

  assign el_w = CW'(el_i);
  assign dt_w = CW'(dt_i);
  assign en   = (el_w >= dt_w);

  always_comb begin
    unique case (sel_i)
      SEL_OFF:     begin hi_o = 1'b0; lo_o = 1'b0; end
      SEL_LOWONLY: begin hi_o = 1'b0; lo_o = 1'b1; end
      default:     begin hi_o = ph_i && en; lo_o = !ph_i && en; end
    endcase
  end

  // R8
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_o && lo_o));
  // R9
  off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == SEL_OFF |-> !hi_o && !lo_o);
  // R10
  lowonly_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i == SEL_LOWONLY |-> lo_o && !hi_o);
  // R7
  gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dt_i != '0 && sel_i == $past(sel_i) && $rose(hi_o)) |-> !$past(lo_o));
endmodule

// File: rtl/hb_sweep_osc.sv
module hb_sweep_osc
  import hb_osc_pkg::*;
#(
  parameter int HW = 16,
  parameter int DW = 8,
  parameter int KW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    sel_i,
  input  logic          sweep_start_i,
  input  logic [HW-1:0] pre_half_i,
  input  logic [HW-1:0] end_half_i,
  input  logic [HW-1:0] op_half_i,
  input  logic [KW-1:0] sweep_k_i,
  input  logic [DW-1:0] dead_i,
  output logic          mclk_o,
  output logic          hi_o,
  output logic          lo_o
);
  sel_e          sel;
  logic [HW-1:0] sweep_h, next_h, el;
  logic          bnd, adv;

  assign sel    = sel_e'(sel_i);
  assign adv    = bnd && (sel == SEL_SWEEP);
  assign next_h = (sel == SEL_OPER) ? op_half_i : sweep_h;

  hb_sweep_step #(.HW(HW), .KW(KW)) u_step (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sweep_start_i),
    .adv_i   (adv),
    .pre_h_i (pre_half_i),
    .end_h_i (end_half_i),
    .k_i     (sweep_k_i),
    .h_o     (sweep_h)
  );

  hb_phase_gen #(.HW(HW)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .next_h_i (next_h),
    .mclk_o   (mclk_o),
    .el_o     (el),
    .bnd_o    (bnd)
  );

  hb_gate_drive #(.HW(HW), .DW(DW)) u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .ph_i   (mclk_o),
    .el_i   (el),
    .dt_i   (dead_i),
    .hi_o   (hi_o),
    .lo_o   (lo_o)
  );
endmodule

// File: tb/sim_hb_sweep_osc.sv
module sim_hb_sweep_osc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic        start = 1'b0;
  logic [15:0] pre_h = 16'd4, end_h = 16'd20, op_h = 16'd7;
  logic [3:0]  k = 4'd2;
  logic [7:0]  dt = 8'd1;
  logic        mclk, hi, lo;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hb_sweep_osc u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .sweep_start_i(start),
    .pre_half_i(pre_h), .end_half_i(end_h), .op_half_i(op_h),
    .sweep_k_i(k), .dead_i(dt), .mclk_o(mclk), .hi_o(hi), .lo_o(lo));

  // behavioural reference
  int m_ph, m_el, m_half, m_sw;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_el = 0; m_half = 1; m_sw = 0;
    end else begin
      int old_sw;
      bit bnd;
      old_sw = m_sw;
      bnd = (m_ph == 0) && (m_el == m_half - 1);
      if (start) m_sw = pre_h;
      else if (bnd && sel == 2) begin
        if (m_sw >= end_h) m_sw = end_h;
        else begin
          int inc;
          inc = (end_h - m_sw) >> k;
          if (inc == 0) inc = 1;
          m_sw = m_sw + inc;
        end
      end
      if (m_el == m_half - 1) begin
        if (m_ph == 0) begin
          m_half = (sel == 3) ? op_h : old_sw;
          if (m_half == 0) m_half = 1;
          m_ph = 1;
        end else m_ph = 0;
        m_el = 0;
      end else m_el++;
    end
  end

  // per-cycle compare against model
  always @(negedge clk) if (rst_n && !done) begin
    bit e_hi, e_lo;
    case (sel)
      2'd0: begin e_hi = 0; e_lo = 0; end
      2'd1: begin e_hi = 0; e_lo = 1; end
      default: begin
        e_hi = (m_ph == 1) && (m_el >= dt);
        e_lo = (m_ph == 0) && (m_el >= dt);
      end
    endcase
    checks++;
    if (mclk !== (m_ph == 1)) begin
      errors++; $display("FAIL R2/R3 mclk act=%0b exp=%0b t=%0t", mclk, m_ph, $time);
    end
    checks++;
    if (hi !== e_hi || lo !== e_lo) begin
      errors++;
      $display("FAIL R7/R9/R10 gates act=%0b%0b exp=%0b%0b sel=%0d t=%0t",
               hi, lo, e_hi, e_lo, sel, $time);
    end
    checks++;
    if (hi && lo) begin
      errors++; $display("FAIL R8 overlap act=11 exp=not 11");
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++; $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic high_len(output int n);
    while (mclk) @(negedge clk);
    while (!mclk) @(negedge clk);
    n = 0;
    while (mclk) begin n++; @(negedge clk); end
  endtask

  task automatic count_hi(int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (hi) c++; end
  endtask

  initial begin
    int n;
    cyc(3);
    // R1 reset state
    chk("R1 mclk in reset", mclk, 0);
    chk("R1 gates in reset", {hi, lo}, 0);
    sel = 2'd2;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 low after release", mclk, 0);
    @(negedge clk);
    chk("R1 first boundary", mclk, 1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    // R4 exponential sweep toward end value
    cyc(800);
    high_len(n); chk("R4 sweep settles on end", n, 20);
    // R5 preheat above end clamps
    pre_h = 16'd30; end_h = 16'd10;
    start = 1'b1; @(negedge clk); start = 1'b0;
    cyc(200);
    high_len(n); chk("R5 clamp to end", n, 10);
    // R6 jump to operate
    sel = 2'd3; cyc(3);
    high_len(n); high_len(n); chk("R6 operate half", n, 7);
    // R7 dead time equal to half keeps gate off
    dt = 8'd7; count_hi(60, n); chk("R7 dt>=half gate off", n, 0);
    dt = 8'd6; count_hi(56, n); chk("R7 one-cycle gate", n, 4);
    dt = 8'd2;
    // R2 zero half clamps to one
    op_h = 16'd0; cyc(30);
    high_len(n); chk("R2 zero half", n, 1);
    // R3 mid-half change waits for boundary
    op_h = 16'd9; cyc(20);
    high_len(n); op_h = 16'd3;
    high_len(n); chk("R3 no runt after change", n >= 3 ? 1 : 0, 1);
    cyc(40);
    // R9 forced off
    sel = 2'd0; cyc(1); count_hi(40, n); chk("R9 off hi", n, 0);
    chk("R9 off lo", lo, 0);
    // R10 low-only, sweep held
    sel = 2'd1; cyc(1); chk("R10 lo held", lo, 1); chk("R10 hi held", hi, 0);
    cyc(50);
    // sweep restart with small k
    sel = 2'd2; pre_h = 16'd3; end_h = 16'd12; k = 4'd0; dt = 8'd1;
    start = 1'b1; @(negedge clk); start = 1'b0;
    cyc(300);
    high_len(n); chk("R4 k=0 end", n, 12);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule